// File: doc/BRIEF.md
# Masked-Write GPIO Bank with Shared Interrupt

This block is a bank of sixteen general-purpose pins behind a small single-cycle register bus. Each pin has a direction bit that turns its driver on and an output latch. A write to the output register carries a per-pin enable mask in its upper half, so software can set or clear any group of pins in one write with no read-modify-write. The pin levels pass through a two-flop synchronizer. They can be read back, and the upper eight pins (8 to 15) feed one registered interrupt request. Each of those pins first goes through its own interrupt-enable bit, and the eight results are ORed together.

A two-bit control register sits beside the pin logic and can always be written. One bit lets the bank advance, standing in for the block clock. The other holds every pin register at zero. Bring-up writes 3 (cleared, clock on) and then 1 (running). Writing 2 parks the bank cleared with its clock off, as a low-power state. A build parameter selects where the eight interrupt-enable bits appear in their register word.

Top module: `pin_bank`

## Requirements
- R1: While rst_n is low, the control, direction, output and interrupt-enable registers, the synchronizer and irqReq all go to 0, so pinOut, pinOutEn and irqReq are 0 and every register reads 0.
- R2: The control register at address 0 holds wdata[1:0] after any write, whatever its current value, and reads back in rdata[1:0]. Bit 0 is the clock enable and bit 1 is the block clear.
- R3: A write to address 2 updates pin n to wdata[n] only where wdata[n+16] is 1, and every other pin keeps its value. pinOut shows the result after the write edge, and address 2 reads it back in rdata[15:0].
- R4: The direction register at address 1 drives pinOutEn directly (1 = output, 0 = input) after the write edge, and reads back in rdata[15:0].
- R5: Address 3 is read-only and returns the pin levels in rdata[15:0]. A level applied before clock edge k is visible after edge k+1, and not after edge k alone.
- R6: irqReq rises one edge after the synchronized level of an enabled pin among 8 to 15 is high, and falls the same way. Pins 0 to 7 never raise it.
- R7: The interrupt-enable register is at address 4. With parameter IEN_AT_LOW = 0 (the default), the enables for pins 8 to 15 are wdata/rdata bits 15:8 and bits 7:0 are not stored. With IEN_AT_LOW = 1, they are bits 7:0.
- R8: While control bit 1 is set, the output, direction and interrupt-enable registers, the synchronizer and irqReq are cleared one edge later and stay 0, and writes to them have no effect.
- R9: While the control value is 0, writes to the direction, output and interrupt-enable registers have no effect, and the pin state and irqReq stay frozen.
- R10: After writing 3 and then 1 to the control register, the bank accepts register writes again and starts from cleared registers.
- R11: rdata is 0 when rdEn is low and when the address is 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe for this cycle |
| rdEn | input | 1 | Register read strobe for this cycle |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data; the upper half is the output mask |
| rdata | output | 32 | Read data, valid in the cycle rdEn is high |
| pinIn | input | 16 | Asynchronous pin levels |
| pinOut | output | 16 | Output latch values |
| pinOutEn | output | 16 | Per-pin driver enable (direction) |
| irqReq | output | 1 | Registered shared interrupt from pins 8 to 15 |

## Verification
Register writes appear at the outputs one edge after the write cycle, and reads are combinational in the cycle rdEn is high. The bench therefore drives at the falling edge, and samples one falling edge after the write edge and within the read cycle. A pin level needs two edges to show in the pin state and a third to move irqReq. The checks sample just before and just after each of those edges, so an extra or missing flop is caught. A clear written to the control register acts one edge after the control write, and the bench waits for that edge before checking the zeroed outputs.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL  = 3'd0,
    ADR_DIR   = 3'd1,
    ADR_OUT   = 3'd2,
    ADR_STATE = 3'd3,
    ADR_IEN   = 3'd4
  } regAddr_e;

  typedef struct packed {
    logic run;    // clock enabled and not cleared
    logic clear;  // block clear bit set
    logic wrDir;
    logic wrOut;
    logic wrIen;
  } bankStrobe_t;

endpackage

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] srcVal;
      if (s == 0) begin : g_first
        assign srcVal = din;
      end else begin : g_next
        assign srcVal = stage[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage[s] <= '0;
        else if (clear)  stage[s] <= '0;
        else if (adv)    stage[s] <= srcVal;
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wdataLow,
  output logic [1:0]        ctrlState,
  output bankStrobe_t       strb
);

  logic [1:0] ctrlReg;
  logic       runNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrlReg <= 2'b00;
    else if (wrEn && addr == ADR_CTRL)   ctrlReg <= wdataLow;
  end

  assign runNow = ctrlReg[0] & ~ctrlReg[1];

  always_comb begin
    strb       = '0;
    strb.run   = runNow;
    strb.clear = ctrlReg[1];
    strb.wrDir = runNow & wrEn & (addr == ADR_DIR);
    strb.wrOut = runNow & wrEn & (addr == ADR_OUT);
    strb.wrIen = runNow & wrEn & (addr == ADR_IEN);
  end

  assign ctrlState = ctrlReg;

  // R2: the control register always accepts a write
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADR_CTRL) |=> ctrlState == $past(wdataLow));

endmodule

// File: rtl/pin_bank_datapath.sv
module pin_bank_datapath
  import pin_bank_pkg::*;
#(
  parameter int PINS       = 16,
  parameter int SHARE_LO   = 8,
  parameter int SHARE_N    = 8,
  parameter bit IEN_AT_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bankStrobe_t       strb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2*PINS-1:0] wdata,
  input  logic [1:0]        ctrlState,
  input  logic [PINS-1:0]   pinIn,
  output logic [2*PINS-1:0] rdata,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOutEn,
  output logic              irqReq
);

  localparam int IEN_POS = IEN_AT_LOW ? 0 : SHARE_LO;

  logic [PINS-1:0]    outReg;
  logic [PINS-1:0]    dirReg;
  logic [SHARE_N-1:0] ienReg;
  logic [PINS-1:0]    pinSync;
  logic [PINS-1:0]    wrMask;
  logic [PINS-1:0]    wrVal;
  logic               sharedHit;
  logic               irqReg;

  assign wrMask = wdata[2*PINS-1:PINS];
  assign wrVal  = wdata[PINS-1:0];

  pin_bank_sync #(.WIDTH(PINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (strb.clear),
    .adv   (strb.run),
    .din   (pinIn),
    .dout  (pinSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg <= '0;
      dirReg <= '0;
      ienReg <= '0;
    end else if (strb.clear) begin
      outReg <= '0;
      dirReg <= '0;
      ienReg <= '0;
    end else begin
      if (strb.wrOut) outReg <= (outReg & ~wrMask) | (wrVal & wrMask);
      if (strb.wrDir) dirReg <= wrVal;
      if (strb.wrIen) ienReg <= wdata[IEN_POS +: SHARE_N];
    end
  end

  assign sharedHit = |(pinSync[SHARE_LO +: SHARE_N] & ienReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irqReg <= 1'b0;
    else if (strb.clear) irqReg <= 1'b0;
    else if (strb.run)   irqReg <= sharedHit;
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      case (addr)
        ADR_CTRL:  rdata[1:0]                = ctrlState;
        ADR_DIR:   rdata[PINS-1:0]           = dirReg;
        ADR_OUT:   rdata[PINS-1:0]           = outReg;
        ADR_STATE: rdata[PINS-1:0]           = pinSync;
        ADR_IEN:   rdata[IEN_POS +: SHARE_N] = ienReg;
        default:   rdata = '0;
      endcase
    end
  end

  assign pinOut   = outReg;
  assign pinOutEn = dirReg;
  assign irqReq   = irqReg;

  // R3: pins outside the write mask keep their value
  assert_masked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrOut |=> ((pinOut ^ $past(pinOut)) & ~$past(wrMask)) == '0);

  // R3: pins inside the write mask take the written value
  assert_masked_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrOut |=> ((pinOut ^ $past(wrVal)) & $past(wrMask)) == '0);

  // R8: the clear bit zeroes the pin registers and the request
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (pinOut == '0 && pinOutEn == '0 && !irqReq));

  // R9: with the clock bit off, nothing moves
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.run && !strb.clear) |=> ($stable(pinOut) && $stable(pinOutEn)
                                    && $stable(irqReq) && $stable(pinSync)));

  // R6: pins 0..7 alone never hold the request up
  assert_low_pins_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.run && pinSync[SHARE_LO +: SHARE_N] == '0) |=> !irqReq);

endmodule

// File: rtl/pin_bank.sv
module pin_bank
  import pin_bank_pkg::*;
#(
  parameter int PINS       = 16,
  parameter bit IEN_AT_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [2*PINS-1:0] wdata,
  output logic [2*PINS-1:0] rdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOutEn,
  output logic              irqReq
);

  localparam int SHARE_N  = PINS / 2;
  localparam int SHARE_LO = PINS - SHARE_N;

  bankStrobe_t strb;
  logic [1:0]  ctrlState;

  pin_bank_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .addr      (addr),
    .wdataLow  (wdata[1:0]),
    .ctrlState (ctrlState),
    .strb      (strb)
  );

  pin_bank_datapath #(
    .PINS       (PINS),
    .SHARE_LO   (SHARE_LO),
    .SHARE_N    (SHARE_N),
    .IEN_AT_LOW (IEN_AT_LOW)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .rdEn      (rdEn),
    .addr      (addr),
    .wdata     (wdata),
    .ctrlState (ctrlState),
    .pinIn     (pinIn),
    .rdata     (rdata),
    .pinOut    (pinOut),
    .pinOutEn  (pinOutEn),
    .irqReq    (irqReq)
  );

  // R11: no read strobe, no data
  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |-> rdata == '0);

endmodule

// File: tb/test_pin_bank.sv
module test_pin_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut;
  logic [15:0] pinOutEn;
  logic        irqReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_DIR = 3'd1, A_OUT = 3'd2,
                         A_STATE = 3'd3, A_IEN = 3'd4;

  // {write word, expected pinOut}
  localparam logic [47:0] OUT_VEC [7] = '{
    {32'hFFFF_1234, 16'h1234},
    {32'h00FF_FFFF, 16'h12FF},
    {32'hFF00_0000, 16'h00FF},
    {32'h0000_FFFF, 16'h00FF},
    {32'h0001_0000, 16'h00FE},
    {32'h8000_8000, 16'h80FE},
    {32'h0F0F_F0F0, 16'h80F0}
  };

  always #5 clk = ~clk;

  pin_bank i_pin_bank (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOutEn(pinOutEn), .irqReq(irqReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    #1;
    d = rdata;
    rdEn = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pinOut", {16'h0, pinOut}, 32'h0);
    check("R1 pinOutEn", {16'h0, pinOutEn}, 32'h0);
    check("R1 irqReq", {31'h0, irqReq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    doRead(A_CTRL, rv); check("R1 ctrl read", rv, 32'h0);

    // R9: clock bit off, write ignored
    doWrite(A_DIR, 32'h0000_FFFF);
    doRead(A_DIR, rv); check("R9 dir write with clock off", rv, 32'h0);

    // R2, R8, R10: bring-up
    doWrite(A_CTRL, 32'h3);
    doRead(A_CTRL, rv); check("R2 ctrl readback 3", rv, 32'h3);
    doWrite(A_DIR, 32'h0000_FFFF);
    doRead(A_DIR, rv); check("R8 dir write while cleared", rv, 32'h0);
    doWrite(A_CTRL, 32'h1);
    doRead(A_CTRL, rv); check("R2 ctrl readback 1", rv, 32'h1);

    // R4: direction
    doWrite(A_DIR, 32'h0000_A5A5);
    check("R4 pinOutEn", {16'h0, pinOutEn}, 32'hA5A5);
    doRead(A_DIR, rv); check("R4 dir readback", rv, 32'hA5A5);

    // R3: masked output writes, table walk
    for (int i = 0; i < 7; i++) begin
      doWrite(A_OUT, OUT_VEC[i][47:16]);
      check($sformatf("R3 vec%0d pinOut", i), {16'h0, pinOut}, {16'h0, OUT_VEC[i][15:0]});
      doRead(A_OUT, rv);
      check($sformatf("R3 vec%0d readback", i), rv, {16'h0, OUT_VEC[i][15:0]});
    end

    // R5: two-edge synchronizer
    pinIn = 16'h5A3C;
    @(negedge clk);
    doRead(A_STATE, rv); check("R5 state after one edge", rv, 32'h0);
    @(negedge clk);
    doRead(A_STATE, rv); check("R5 state after two edges", rv, 32'h5A3C);

    // R7: enable for pin 10 at bit 10
    doWrite(A_IEN, 32'h0000_0400);
    doRead(A_IEN, rv); check("R7 ien readback", rv, 32'h0400);
    check("R6 pin10 low no irq", {31'h0, irqReq}, 32'h0);

    // R6: irq three edges after the pin changes
    pinIn = 16'h0400;
    waitEdges(2);
    check("R6 irq not before third edge", {31'h0, irqReq}, 32'h0);
    waitEdges(1);
    check("R6 irq after third edge", {31'h0, irqReq}, 32'h1);
    pinIn = 16'h00FF;
    waitEdges(3);
    check("R6 low pins do not request", {31'h0, irqReq}, 32'h0);

    // R7: bits 7:0 are not stored at the default position
    doWrite(A_IEN, 32'h0000_00FF);
    doRead(A_IEN, rv); check("R7 low byte ignored", rv, 32'h0);
    pinIn = 16'hFF00;
    waitEdges(4);
    check("R7 no irq with wrong position", {31'h0, irqReq}, 32'h0);
    doWrite(A_IEN, 32'h0000_FF00);
    check("R6 irq one edge after enable", {31'h0, irqReq}, 32'h0);
    @(negedge clk);
    check("R6 irq after enable", {31'h0, irqReq}, 32'h1);

    // R9: clock off freezes state and blocks writes
    doWrite(A_CTRL, 32'h0);
    pinIn = 16'h0000;
    waitEdges(4);
    doRead(A_STATE, rv); check("R9 state frozen", rv, 32'hFF00);
    check("R9 irq frozen", {31'h0, irqReq}, 32'h1);
    doWrite(A_OUT, 32'hFFFF_FFFF);
    check("R9 out write ignored", {16'h0, pinOut}, 32'h80F0);
    doWrite(A_DIR, 32'h0);
    check("R9 dir write ignored", {16'h0, pinOutEn}, 32'hA5A5);
    doWrite(A_CTRL, 32'h1);
    waitEdges(4);
    doRead(A_STATE, rv); check("R9 state resumes", rv, 32'h0);
    check("R9 irq resumes", {31'h0, irqReq}, 32'h0);

    // R8: low-power clear
    doWrite(A_CTRL, 32'h2);
    @(negedge clk);
    check("R8 pinOut cleared", {16'h0, pinOut}, 32'h0);
    check("R8 pinOutEn cleared", {16'h0, pinOutEn}, 32'h0);
    doRead(A_IEN, rv); check("R8 ien cleared", rv, 32'h0);
    doRead(A_CTRL, rv); check("R2 ctrl readback 2", rv, 32'h2);
    doWrite(A_CTRL, 32'h3);
    doWrite(A_OUT, 32'hFFFF_FFFF);
    check("R8 out write while cleared", {16'h0, pinOut}, 32'h0);

    // R10: release and use
    doWrite(A_CTRL, 32'h1);
    doWrite(A_OUT, 32'h0003_0001);
    check("R10 write after bring-up", {16'h0, pinOut}, 32'h0001);

    // R11: unmapped and idle reads
    doRead(3'd6, rv); check("R11 unmapped read", rv, 32'h0);
    #1;
    check("R11 rdEn low", rdata, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule